// File: doc/BRIEF.md
# Interrupt Arbitration and Wait Controller

This block sits next to an 8-bit processor core and answers one question at each instruction boundary: should the core take an interrupt, and which one, or should it stall or go on to fetch the next opcode. It watches three interrupt pins: one edge-triggered non-maskable line and two level-sensitive maskable lines, a fast one and a normal one. It also watches the two mask bits from the core's condition codes, a strobe for each write to the hardware stack pointer, and pulses that place it in one of two wait states.

The core pulses `step_i` at every boundary. One cycle later the block raises exactly one response. `fetch_o` and `stall_o` are single-cycle pulses. `take_o` is a held request that carries a type code and a skip-stacking flag, and it stays up until the core pulses `ack_i`. In the acknowledge cycle the block tells the core which mask bits to set and, for a non-maskable event, acknowledges its service. The non-maskable input is ignored until software has written the stack pointer once. The two wait states wake on different conditions: the synchronise wait wakes on any pending line whatever the masks, while the wait-with-saved-state wakes only on a line that can actually be serviced.

Top module: `irq_arbiter`

## Requirements
- R1: While `rst` is high, `set_imask_o` and `set_fmask_o` are high. After a synchronous reset, `take_o`, `stall_o`, `fetch_o` and `nmi_ack_o` are low, and the arm state, the non-maskable latch and both wait flags are clear.
- R2: A rising edge on `nmi_pin_i` is latched only when the block is armed. Arming takes effect in the cycle after the first `sp_write_i` pulse. Edges seen earlier are dropped, and a later step then yields `fetch_o`.
- R3: Once armed, the block stays armed through any number of services, and only reset disarms it.
- R4: The non-maskable latch clears only when its request is acknowledged, and `nmi_ack_o` is high in that acknowledge cycle. A pin held high after service produces no second request.
- R5: The priority order is non-maskable, then fast, then normal. The type code on `take_kind_o` is 0 for none, 1 for non-maskable, 2 for fast and 3 for normal.
- R6: The fast line is taken only while `fmask_i` is 0, and the normal line only while `imask_i` is 0. The non-maskable line ignores both masks.
- R7: The level lines are never cleared by the block. A line still high after its service is taken again at the next step once its mask is clear.
- R8: In an acknowledge cycle, a non-maskable or fast request drives both `set_imask_o` and `set_fmask_o` high. A normal request drives only `set_imask_o` high.
- R9: `take_o` and `take_kind_o` stay unchanged until `ack_i`. Steps that arrive while a request is held produce no response.
- R10: A step with no serviceable line and no wait state gives a one-cycle `fetch_o`.
- R11: After `sync_enter_i`, each step stalls until some line is pending, masked or not. The step that sees a line leaves the synchronise state and gives `take_o` if a line is serviceable, or `fetch_o` if none is.
- R12: After `cwai_enter_i`, each step stalls until a serviceable line is present. A masked line keeps the block stalling.
- R13: A request taken out of the wait-with-saved-state raises `skip_stack_o` and clears that wait state. Any other request has `skip_stack_o` low.
- R14: Every response appears in the cycle after the step. At most one of `stall_o`, `fetch_o` and a newly raised `take_o` is active in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Instruction-boundary decision strobe |
| ack_i | input | 1 | Core accepts the held interrupt request |
| nmi_pin_i | input | 1 | Non-maskable interrupt pin, edge-sensitive |
| firq_pin_i | input | 1 | Fast interrupt pin, level-sensitive |
| irq_pin_i | input | 1 | Normal interrupt pin, level-sensitive |
| imask_i | input | 1 | Normal-interrupt mask bit from the condition codes |
| fmask_i | input | 1 | Fast-interrupt mask bit from the condition codes |
| sp_write_i | input | 1 | Pulse on each hardware stack pointer write |
| sync_enter_i | input | 1 | Pulse that enters the synchronise wait |
| cwai_enter_i | input | 1 | Pulse that enters the wait with registers already saved |
| take_o | output | 1 | Interrupt request, held until ack |
| take_kind_o | output | 2 | Type code of the held request |
| skip_stack_o | output | 1 | Registers already saved, skip stacking |
| stall_o | output | 1 | One-cycle stall response to a step |
| fetch_o | output | 1 | One-cycle proceed-to-fetch response to a step |
| nmi_ack_o | output | 1 | Non-maskable request serviced in this cycle |
| set_imask_o | output | 1 | Core must set the normal mask bit |
| set_fmask_o | output | 1 | Core must set the fast mask bit |

## Verification
The embedded properties check on every cycle that a held request stays frozen until acknowledged, that responses follow a step and do not overlap, that no masked line is ever granted, that a non-maskable grant only occurs when armed, that the arm state never falls, and that the skip flag matches the wait state at grant time. Only the bench scenarios show the orderings over time: that edges before the first stack write are lost for good, that the synchronise wait wakes on a masked line and then fetches, that a masked line keeps the saved-state wait stalled, that level lines come back after service, and that a second reset disarms the non-maskable input.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        IK_NONE = 2'd0,
        IK_NMI  = 2'd1,
        IK_FIRQ = 2'd2,
        IK_IRQ  = 2'd3
    } irq_kind_e;

    typedef struct packed {
        logic nmi;
        logic firq;
        logic irq;
    } line_set_t;

    typedef struct packed {
        logic      valid;
        irq_kind_e kind;
        logic      skip_stack;
    } take_req_t;

    function automatic irq_kind_e pick_winner(line_set_t l, logic imask, logic fmask);
        if (l.nmi)
            return IK_NMI;
        if (l.firq && !fmask)
            return IK_FIRQ;
        if (l.irq && !imask)
            return IK_IRQ;
        return IK_NONE;
    endfunction

    function automatic logic any_line(line_set_t l);
        return l.nmi | l.firq | l.irq;
    endfunction

endpackage

// File: rtl/irq_nmi_gate.sv
module irq_nmi_gate (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic sp_write_i,
    input  logic service_i,
    output logic armed_o,
    output logic pending_o
);
    logic armed_q;
    logic prev_q;
    logic latch_q;
    logic edge_seen;

    assign edge_seen = pin_i & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            armed_q <= armed_q | sp_write_i;
            prev_q  <= pin_i;
            if (edge_seen && armed_q)
                latch_q <= 1'b1;
            else if (service_i)
                latch_q <= 1'b0;
        end
    end

    assign armed_o   = armed_q;
    assign pending_o = latch_q;

    AST_NMI_EDGE_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        $rose(latch_q) |-> $past(armed_q)); // R2
    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (rst)
        armed_q |=> armed_q); // R3
    AST_NMI_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        latch_q && !service_i |=> latch_q); // R4

endmodule

// File: rtl/irq_wait_ctrl.sv
module irq_wait_ctrl
    import irq_arb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sync_enter_i,
    input  logic      cwai_enter_i,
    input  logic      decide_i,
    input  logic      take_fire_i,
    input  line_set_t lines_i,
    input  logic      imask_i,
    input  logic      fmask_i,
    output logic      sync_o,
    output logic      cwai_o,
    output logic      hold_o
);
    logic sync_q;
    logic cwai_q;
    logic sync_wake;
    logic cwai_wake;

    assign sync_wake = any_line(lines_i);
    assign cwai_wake = (pick_winner(lines_i, imask_i, fmask_i) != IK_NONE);
    assign hold_o    = (sync_q & ~sync_wake) | (cwai_q & ~cwai_wake);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            cwai_q <= 1'b0;
        end else begin
            if (sync_enter_i)
                sync_q <= 1'b1;
            else if (decide_i && sync_q && sync_wake)
                sync_q <= 1'b0;
            if (cwai_enter_i)
                cwai_q <= 1'b1;
            else if (take_fire_i)
                cwai_q <= 1'b0;
        end
    end

    assign sync_o = sync_q;
    assign cwai_o = cwai_q;

    AST_CWAI_LEFT_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
        take_fire_i && !cwai_enter_i |=> !cwai_q); // R13
    AST_SYNC_KEPT_WHILE_QUIET: assert property (@(posedge clk) disable iff (rst)
        sync_q && !sync_wake |=> sync_q); // R11

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic              ack_i,
    input  logic              nmi_pin_i,
    input  logic              firq_pin_i,
    input  logic              irq_pin_i,
    input  logic              imask_i,
    input  logic              fmask_i,
    input  logic              sp_write_i,
    input  logic              sync_enter_i,
    input  logic              cwai_enter_i,
    output logic              take_o,
    output logic [KIND_W-1:0] take_kind_o,
    output logic              skip_stack_o,
    output logic              stall_o,
    output logic              fetch_o,
    output logic              nmi_ack_o,
    output logic              set_imask_o,
    output logic              set_fmask_o
);
    take_req_t req_q;
    logic      stall_q;
    logic      fetch_q;
    logic      nmi_pending;
    logic      nmi_armed;
    logic      nmi_service;
    logic      accept_ack;
    logic      decide;
    logic      hold;
    logic      go;
    logic      take_fire;
    logic      sync_q;
    logic      cwai_q;
    line_set_t lines;
    irq_kind_e winner;

    assign lines.nmi  = nmi_pending;
    assign lines.firq = firq_pin_i;
    assign lines.irq  = irq_pin_i;

    assign accept_ack  = ack_i & req_q.valid;
    assign nmi_service = accept_ack & (req_q.kind == IK_NMI);
    assign decide      = step_i & ~req_q.valid;
    assign winner      = pick_winner(lines, imask_i, fmask_i);
    assign go          = decide & ~hold;
    assign take_fire   = go & (winner != IK_NONE);

    irq_nmi_gate u_nmi_gate (
        .clk        (clk),
        .rst        (rst),
        .pin_i      (nmi_pin_i),
        .sp_write_i (sp_write_i),
        .service_i  (nmi_service),
        .armed_o    (nmi_armed),
        .pending_o  (nmi_pending)
    );

    irq_wait_ctrl u_wait_ctrl (
        .clk          (clk),
        .rst          (rst),
        .sync_enter_i (sync_enter_i),
        .cwai_enter_i (cwai_enter_i),
        .decide_i     (decide),
        .take_fire_i  (take_fire),
        .lines_i      (lines),
        .imask_i      (imask_i),
        .fmask_i      (fmask_i),
        .sync_o       (sync_q),
        .cwai_o       (cwai_q),
        .hold_o       (hold)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= '0;
            stall_q <= 1'b0;
            fetch_q <= 1'b0;
        end else begin
            stall_q <= decide & hold;
            fetch_q <= go & (winner == IK_NONE);
            if (take_fire) begin
                req_q.valid      <= 1'b1;
                req_q.kind       <= winner;
                req_q.skip_stack <= cwai_q;
            end else if (accept_ack) begin
                req_q <= '0;
            end
        end
    end

    assign take_o       = req_q.valid;
    assign take_kind_o  = req_q.valid ? req_q.kind : IK_NONE;
    assign skip_stack_o = req_q.valid & req_q.skip_stack;
    assign stall_o      = stall_q;
    assign fetch_o      = fetch_q;
    assign nmi_ack_o    = nmi_service;
    assign set_imask_o  = rst | accept_ack;
    assign set_fmask_o  = rst | (accept_ack & (req_q.kind != IK_IRQ));

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !take_o && !stall_o && !fetch_o); // R1
    AST_NMI_ONLY_ARMED: assert property (@(posedge clk) disable iff (rst)
        take_o && take_kind_o == IK_NMI |-> nmi_armed); // R2
    AST_TAKE_HELD: assert property (@(posedge clk) disable iff (rst)
        take_o && !ack_i |=> take_o && $stable(take_kind_o) && $stable(skip_stack_o)); // R9
    AST_FIRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        $rose(take_o) && take_kind_o == IK_FIRQ |-> !$past(fmask_i)); // R6
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        $rose(take_o) && take_kind_o == IK_IRQ |-> !$past(imask_i)); // R6
    AST_SKIP_FROM_CWAI: assert property (@(posedge clk) disable iff (rst)
        $rose(take_o) |-> skip_stack_o == $past(cwai_q)); // R13
    AST_STALL_ONLY_WAITING: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> $past(sync_q || cwai_q)); // R11
    AST_RESP_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
        stall_o || fetch_o || $rose(take_o) |-> $past(step_i)); // R14
    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
        stall_o || fetch_o |-> !take_o && !(stall_o && fetch_o)); // R14

endmodule

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;

    logic clk = 1'b0;
    logic rst, step, ack, nmi, firq, irq, imask, fmask, spw, sync_en, cwai_en;
    logic       take_o, skip_stack_o, stall_o, fetch_o, nmi_ack_o, set_imask_o, set_fmask_o;
    logic [1:0] take_kind_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam int RESP_NONE  = 0;
    localparam int RESP_FETCH = 1;
    localparam int RESP_STALL = 2;
    localparam int RESP_TAKE  = 3;

    always #5 clk = ~clk;

    irq_arbiter i_irq_arbiter (
        .clk(clk), .rst(rst), .step_i(step), .ack_i(ack),
        .nmi_pin_i(nmi), .firq_pin_i(firq), .irq_pin_i(irq),
        .imask_i(imask), .fmask_i(fmask), .sp_write_i(spw),
        .sync_enter_i(sync_en), .cwai_enter_i(cwai_en),
        .take_o(take_o), .take_kind_o(take_kind_o), .skip_stack_o(skip_stack_o),
        .stall_o(stall_o), .fetch_o(fetch_o), .nmi_ack_o(nmi_ack_o),
        .set_imask_o(set_imask_o), .set_fmask_o(set_fmask_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int resp_now();
        if (int'(stall_o) + int'(fetch_o) + int'(take_o) > 1) return 9;
        if (take_o)  return RESP_TAKE;
        if (stall_o) return RESP_STALL;
        if (fetch_o) return RESP_FETCH;
        return RESP_NONE;
    endfunction

    task automatic step_expect(input string tag, input int exp_resp, input int exp_kind, input int exp_skip);
        @(negedge clk) step = 1'b1;
        @(negedge clk) step = 1'b0;
        chk({tag, " R14 response"}, resp_now(), exp_resp);
        if (exp_resp == RESP_TAKE) begin
            chk({tag, " R5 kind"}, int'(take_kind_o), exp_kind);
            chk({tag, " R13 skip"}, int'(skip_stack_o), exp_skip);
        end
    endtask

    task automatic do_ack(input string tag, input int exp_nack, input int exp_si, input int exp_sf);
        @(negedge clk) ack = 1'b1;
        #1;
        chk({tag, " R4 nmi_ack"}, int'(nmi_ack_o), exp_nack);
        chk({tag, " R8 set_imask"}, int'(set_imask_o), exp_si);
        chk({tag, " R8 set_fmask"}, int'(set_fmask_o), exp_sf);
        if (set_imask_o) imask = 1'b1;
        if (set_fmask_o) fmask = 1'b1;
        @(negedge clk) ack = 1'b0;
        chk({tag, " R9 take dropped after ack"}, int'(take_o), 0);
    endtask

    task automatic apply_reset();
        @(negedge clk) rst = 1'b1;
        #1;
        chk("R1 set_imask in reset", int'(set_imask_o), 1);
        chk("R1 set_fmask in reset", int'(set_fmask_o), 1);
        imask = 1'b1; fmask = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(1);
        chk("R1 outputs idle after reset", resp_now(), RESP_NONE);
        chk("R1 nmi_ack low after reset", int'(nmi_ack_o), 0);
    endtask

    task automatic t_unarmed_nmi();
        @(negedge clk) nmi = 1'b1;
        idle(2);
        nmi = 1'b0;
        step_expect("R2 unarmed edge dropped", RESP_FETCH, 0, 0);
        @(negedge clk) begin nmi = 1'b1; spw = 1'b1; end
        @(negedge clk) spw = 1'b0;
        idle(1);
        nmi = 1'b0;
        step_expect("R2 edge with arm strobe dropped", RESP_FETCH, 0, 0);
    endtask

    task automatic t_armed_nmi();
        @(negedge clk) nmi = 1'b1;
        idle(2);
        step_expect("R6 nmi ignores masks", RESP_TAKE, 1, 0);
        do_ack("R4 nmi service", 1, 1, 1);
        step_expect("R4 held pin no second take", RESP_FETCH, 0, 0);
        nmi = 1'b0;
        idle(1);
        @(negedge clk) nmi = 1'b1;
        idle(2);
        nmi = 1'b0;
        step_expect("R3 still armed after service", RESP_TAKE, 1, 0);
        do_ack("R3 second nmi service", 1, 1, 1);
    endtask

    task automatic t_priority();
        imask = 1'b0; fmask = 1'b0;
        firq = 1'b1; irq = 1'b1;
        @(negedge clk) nmi = 1'b1;
        idle(2);
        nmi = 1'b0;
        step_expect("R5 nmi beats both", RESP_TAKE, 1, 0);
        do_ack("R8 nmi ack masks", 1, 1, 1);
        imask = 1'b0; fmask = 1'b0;
        step_expect("R5 firq beats irq", RESP_TAKE, 2, 0);
        do_ack("R8 firq ack masks", 0, 1, 1);
        imask = 1'b0; fmask = 1'b0;
        firq = 1'b0;
        step_expect("R5 irq alone", RESP_TAKE, 3, 0);
        do_ack("R8 irq ack masks", 0, 1, 0);
        step_expect("R6 irq masked by I", RESP_FETCH, 0, 0);
        imask = 1'b0;
        step_expect("R7 level irq returns", RESP_TAKE, 3, 0);
        do_ack("R7 irq ack", 0, 1, 0);
        irq = 1'b0;
        imask = 1'b0;
    endtask

    task automatic t_hold();
        firq = 1'b1; fmask = 1'b0;
        step_expect("R9 firq request", RESP_TAKE, 2, 0);
        idle(3);
        chk("R9 held", int'(take_o), 1);
        chk("R9 kind stable", int'(take_kind_o), 2);
        step_expect("R9 step ignored while held", RESP_TAKE, 2, 0);
        do_ack("R9 firq ack", 0, 1, 1);
        firq = 1'b0;
        step_expect("R10 quiet step fetches", RESP_FETCH, 0, 0);
        irq = 1'b1; firq = 1'b1;
        step_expect("R6 both masked fetch", RESP_FETCH, 0, 0);
        irq = 1'b0; firq = 1'b0;
    endtask

    task automatic t_sync();
        imask = 1'b1; fmask = 1'b1;
        @(negedge clk) sync_en = 1'b1;
        @(negedge clk) sync_en = 1'b0;
        for (int k = 0; k < 3; k++)
            step_expect("R11 sync stalls", RESP_STALL, 0, 0);
        irq = 1'b1;
        step_expect("R11 masked line wakes sync", RESP_FETCH, 0, 0);
        step_expect("R11 sync left", RESP_FETCH, 0, 0);
        irq = 1'b0;
        @(negedge clk) sync_en = 1'b1;
        @(negedge clk) sync_en = 1'b0;
        step_expect("R11 sync stalls again", RESP_STALL, 0, 0);
        fmask = 1'b0; firq = 1'b1;
        step_expect("R11 sync wakes into take", RESP_TAKE, 2, 0);
        do_ack("R11 firq ack", 0, 1, 1);
        firq = 1'b0;
    endtask

    task automatic t_cwai();
        imask = 1'b1; fmask = 1'b1;
        @(negedge clk) cwai_en = 1'b1;
        @(negedge clk) cwai_en = 1'b0;
        step_expect("R12 cwai stalls quiet", RESP_STALL, 0, 0);
        irq = 1'b1;
        step_expect("R12 masked irq keeps stall", RESP_STALL, 0, 0);
        imask = 1'b0;
        step_expect("R13 take from cwai", RESP_TAKE, 3, 1);
        do_ack("R13 irq ack", 0, 1, 0);
        imask = 1'b0;
        step_expect("R13 cwai cleared", RESP_TAKE, 3, 0);
        do_ack("R13 irq ack 2", 0, 1, 0);
        irq = 1'b0;
    endtask

    task automatic t_rearm();
        apply_reset();
        @(negedge clk) nmi = 1'b1;
        idle(2);
        nmi = 1'b0;
        step_expect("R3 reset disarms", RESP_FETCH, 0, 0);
    endtask

    initial begin
        rst = 1'b1; step = 0; ack = 0; nmi = 0; firq = 0; irq = 0;
        imask = 1; fmask = 1; spw = 0; sync_en = 0; cwai_en = 0;
        apply_reset();
        t_unarmed_nmi();
        t_armed_nmi();
        t_priority();
        t_hold();
        t_sync();
        t_cwai();
        t_rearm();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule